// File: doc/BRIEF.md
# Interrupt Gate Dispatch Sequencer

This block performs the processor-side entry work for an interrupt whose vector has already been accepted. It keeps a 48-bit table register. The upper 32 bits hold the byte address of the gate table and the lower 16 bits hold its limit, which is the highest valid byte offset. Software loads this register through a write port, and the port only takes effect while the current privilege is 0. The stored value can be read back at any privilege.

When a vector arrives, the sequencer does the following, in order:

- It checks that the 8-byte entry lies inside the limit.
- It fetches the entry through a 64-bit read port.
- It decodes the gate and checks it.
- If the interrupted code is not at privilege 0, it moves to the ring-0 stack.
- It pushes the return frame through a write port that uses a ready handshake.

When the frame is written, it reports the handler's code selector, its entry offset and the new interrupt-flag value. The return frame is the old stack segment and pointer (only when privilege changes), then flags, code selector and return offset.

The surrounding core supplies the interrupted context: privilege, flags, CS, IP, SS, SP and the ring-0 stack pair. The core then acts on the single-cycle `done` or `fault` pulse. The handler always runs at privilege 0. Stack addresses are flat; segment bases are not applied.

Top module: `intr_gate_seq`

## Requirements
- R1: After reset `tbl_rd_data` is 0. A write with `tbl_wr_en` high while `cur_cpl` is 0 updates the register, and the value is visible on `tbl_rd_data` the next cycle. Bits 47:16 are the table base and bits 15:0 are the limit.
- R2: A table write while `cur_cpl` is not 0 is ignored, and `tbl_rd_data` keeps its value.
- R3: If vector*8+7 is greater than the limit, `fault` pulses in the cycle after the vector is accepted. In that case no read is issued and nothing is written.
- R4: The gate is read in a single access at address base + vector*8. The gate's fields are:
  - bits 15:0: offset low half
  - bits 31:16: code selector
  - bits 43:40: type
  - bit 44: must be 0
  - bits 46:45: DPL
  - bit 47: present
  - bits 63:48: offset high half
- R5: A gate is faulted, with no writes, if any of the following holds:
  - bit 47 is 0;
  - bit 44 is 1;
  - the type is not one of 0x6, 0x7, 0xE or 0xF.
- R6: When `cur_cpl` is 0, three items are pushed on the current stack, in the order FLAGS, CS, IP. Each write address is the previous stack pointer minus the item size (pre-decrement).
- R7: When `cur_cpl` is not 0, the stack becomes `ring0_ss`/`ring0_sp`, and the old SS and old SP are pushed before FLAGS, CS and IP (five items).
- R8: Types 0x6 and 0x7 push 2-byte items (`mwr_size`=0, low 16 bits of each value). Types 0xE and 0xF push 4-byte items (`mwr_size`=1, with selectors zero-extended).
- R9: Interrupt gates (0x6, 0xE) give `new_if`=0. Trap gates (0x7, 0xF) give `new_if` equal to bit 9 of `cur_flags`.
- R10: `done` pulses for one cycle, in the cycle after the last write is accepted. With it come:
  - `new_cs`: the gate selector;
  - `new_eip`: the offset, with the upper half zero for 16-bit gates;
  - `new_cpl`: 0;
  - `new_ss`: the stack segment in use;
  - `new_sp`: the last write address.
- R11: A read or write request stays asserted with stable address and data until its ready input is high.
- R12: `busy` is high from the cycle after acceptance until `done`. A vector is only accepted while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cur_cpl | input | 2 | Current privilege level |
| tbl_wr_en | input | 1 | Table register write strobe |
| tbl_wr_data | input | 48 | Value to load: base in 47:16, limit in 15:0 |
| tbl_rd_data | output | 48 | Table register readback |
| irq_valid | input | 1 | Accepted vector is presented |
| irq_vector | input | 8 | Vector number |
| busy | output | 1 | Entry sequence in progress |
| cur_flags | input | 32 | Flags of the interrupted code |
| cur_cs | input | 16 | Code selector of the interrupted code |
| cur_ip | input | 32 | Return offset |
| cur_ss | input | 16 | Current stack segment |
| cur_sp | input | 32 | Current stack pointer |
| ring0_ss | input | 16 | Ring-0 stack segment |
| ring0_sp | input | 32 | Ring-0 stack pointer |
| mrd_req | output | 1 | Gate read request |
| mrd_addr | output | 32 | Gate read address |
| mrd_rdy | input | 1 | Read data valid / accepted |
| mrd_data | input | 64 | Gate descriptor |
| mwr_req | output | 1 | Stack write request |
| mwr_addr | output | 32 | Stack write address |
| mwr_data | output | 32 | Stack write data |
| mwr_size | output | 1 | 1 = 4-byte item, 0 = 2-byte item |
| mwr_rdy | input | 1 | Write accepted |
| done | output | 1 | Entry complete pulse |
| fault | output | 1 | Entry refused pulse |
| new_cs | output | 16 | Handler code selector |
| new_eip | output | 32 | Handler entry offset |
| new_cpl | output | 2 | New privilege level |
| new_if | output | 1 | New interrupt-flag value |
| new_ss | output | 16 | Stack segment after entry |
| new_sp | output | 32 | Stack pointer after entry |

## Verification
The checker enforces the following properties on every cycle:

- the table register cannot change without a privileged write;
- both memory requests hold until their ready input;
- consecutive stack writes step down by exactly the item size;
- `done` and `fault` are exclusive and arrive only once the block is idle again;
- the privilege level reported with `done` is 0.

Other behaviour depends on descriptor contents and the interrupted context, so only the bench scenarios show it:

- which items are pushed, and in what order and width;
- which gates and vectors fault;
- the value of the new interrupt flag;
- the selector and offset that are reported.

The scenarios include the vector at the exact limit boundary and the first vector beyond it.

// File: rtl/igs_pkg.sv
package igs_pkg;

  // Frame items in push order; the numeric order is the push sequence.
  typedef enum logic [2:0] {
    IT_SS    = 3'd0,
    IT_SP    = 3'd1,
    IT_FLAGS = 3'd2,
    IT_CS    = 3'd3,
    IT_IP    = 3'd4
  } item_t;

  typedef enum logic [1:0] {
    S_IDLE,
    S_FETCH,
    S_CHECK,
    S_PUSH
  } seq_state_t;

  localparam int GATE_BYTES = 8;
  localparam int GATE_W     = GATE_BYTES * 8;
  localparam int IF_BIT     = 9;

endpackage

// File: rtl/igs_tablereg.sv
module igs_tablereg #(
  parameter int ADDR_W = 32,
  parameter int LIM_W  = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [1:0]              cpl,
  input  logic [ADDR_W+LIM_W-1:0] wr_data,
  output logic [ADDR_W+LIM_W-1:0] rd_data,
  output logic [ADDR_W-1:0]       base,
  output logic [LIM_W-1:0]        limit
);
  localparam int DTR_W = ADDR_W + LIM_W;

  logic [DTR_W-1:0] dtr_q;

  always_ff @(posedge clk) begin
    if (rst)                          dtr_q <= '0;
    else if (wr_en && (cpl == 2'd0))  dtr_q <= wr_data;
  end

  assign rd_data = dtr_q;
  assign base    = dtr_q[DTR_W-1:LIM_W];
  assign limit   = dtr_q[LIM_W-1:0];
endmodule

// File: rtl/igs_gatedec.sv
module igs_gatedec (
  input  logic [63:0] raw,
  output logic        ok,
  output logic        wide,
  output logic        trap,
  output logic [15:0] sel,
  output logic [31:0] offset
);
  logic [3:0] kind;
  logic       present;
  logic       sys_zero;

  always_comb begin
    kind     = raw[43:40];
    present  = raw[47];
    sys_zero = ~raw[44];
    // 0x6, 0x7, 0xE, 0xF share bits 2:1 = 11; bit 3 selects width, bit 0 trap.
    ok       = present && sys_zero && (kind[2:1] == 2'b11);
    wide     = kind[3];
    trap     = kind[0];
    sel      = raw[31:16];
    offset   = {raw[63:48], raw[15:0]};
  end
endmodule

// File: rtl/igs_frame.sv
module igs_frame
  import igs_pkg::*;
(
  input  item_t       idx,
  input  logic        wide,
  input  logic [15:0] ss,
  input  logic [31:0] sp,
  input  logic [31:0] flags,
  input  logic [15:0] cs,
  input  logic [31:0] ip,
  output logic [31:0] data
);
  logic [31:0] full;

  always_comb begin
    case (idx)
      IT_SS:    full = {16'h0, ss};
      IT_SP:    full = sp;
      IT_FLAGS: full = flags;
      IT_CS:    full = {16'h0, cs};
      IT_IP:    full = ip;
      default:  full = '0;
    endcase
    data = wide ? full : {16'h0, full[15:0]};
  end
endmodule

// File: rtl/intr_gate_seq.sv
module intr_gate_seq
  import igs_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LIM_W  = 16,
  parameter int VEC_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [1:0]              cur_cpl,
  input  logic                    tbl_wr_en,
  input  logic [ADDR_W+LIM_W-1:0] tbl_wr_data,
  output logic [ADDR_W+LIM_W-1:0] tbl_rd_data,
  input  logic                    irq_valid,
  input  logic [VEC_W-1:0]        irq_vector,
  output logic                    busy,
  input  logic [31:0]             cur_flags,
  input  logic [15:0]             cur_cs,
  input  logic [31:0]             cur_ip,
  input  logic [15:0]             cur_ss,
  input  logic [31:0]             cur_sp,
  input  logic [15:0]             ring0_ss,
  input  logic [31:0]             ring0_sp,
  output logic                    mrd_req,
  output logic [ADDR_W-1:0]       mrd_addr,
  input  logic                    mrd_rdy,
  input  logic [63:0]             mrd_data,
  output logic                    mwr_req,
  output logic [ADDR_W-1:0]       mwr_addr,
  output logic [31:0]             mwr_data,
  output logic                    mwr_size,
  input  logic                    mwr_rdy,
  output logic                    done,
  output logic                    fault,
  output logic [15:0]             new_cs,
  output logic [31:0]             new_eip,
  output logic [1:0]              new_cpl,
  output logic                    new_if,
  output logic [15:0]             new_ss,
  output logic [31:0]             new_sp
);
  localparam int SHIFT = $clog2(GATE_BYTES);
  localparam int OFF_W = VEC_W + SHIFT;

  logic [ADDR_W-1:0] tbl_base;
  logic [LIM_W-1:0]  tbl_limit;

  igs_tablereg #(.ADDR_W(ADDR_W), .LIM_W(LIM_W)) u_tbl (
    .clk(clk), .rst(rst), .wr_en(tbl_wr_en), .cpl(cur_cpl),
    .wr_data(tbl_wr_data), .rd_data(tbl_rd_data),
    .base(tbl_base), .limit(tbl_limit)
  );

  seq_state_t  state;
  logic [63:0] gate_q;
  logic [1:0]  cpl_q;
  logic [31:0] flags_q, ip_q, sp_q, r0sp_q;
  logic [15:0] cs_q, ss_q, r0ss_q;
  logic        wide_q, trap_q;
  item_t       idx_q;

  // Gate decode
  logic        dec_ok, dec_wide, dec_trap;
  logic [15:0] dec_sel;
  logic [31:0] dec_off;

  igs_gatedec u_dec (
    .raw(gate_q), .ok(dec_ok), .wide(dec_wide), .trap(dec_trap),
    .sel(dec_sel), .offset(dec_off)
  );

  // Bounds check on the accepted vector
  logic [OFF_W-1:0] end_off;
  logic             out_of_range;
  assign end_off      = {irq_vector, {SHIFT{1'b1}}};
  assign out_of_range = (ADDR_W'(end_off) > ADDR_W'(tbl_limit));

  // Push bookkeeping
  logic              priv_chg;
  item_t             first_idx, nxt_idx;
  logic              frame_wide;
  logic [ADDR_W-1:0] step, start_sp;
  logic [31:0]       frame_data;

  assign priv_chg   = (cpl_q != 2'd0);
  assign first_idx  = priv_chg ? IT_SS : IT_FLAGS;
  assign nxt_idx    = (state == S_CHECK) ? first_idx : item_t'(idx_q + 3'd1);
  assign frame_wide = (state == S_CHECK) ? dec_wide : wide_q;
  assign step       = frame_wide ? ADDR_W'(4) : ADDR_W'(2);
  assign start_sp   = priv_chg ? ADDR_W'(r0sp_q) : ADDR_W'(sp_q);

  igs_frame u_frame (
    .idx(nxt_idx), .wide(frame_wide), .ss(ss_q), .sp(sp_q),
    .flags(flags_q), .cs(cs_q), .ip(ip_q), .data(frame_data)
  );

  assign busy = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      gate_q   <= '0;
      cpl_q    <= '0;
      flags_q  <= '0;
      ip_q     <= '0;
      sp_q     <= '0;
      r0sp_q   <= '0;
      cs_q     <= '0;
      ss_q     <= '0;
      r0ss_q   <= '0;
      wide_q   <= 1'b0;
      trap_q   <= 1'b0;
      idx_q    <= IT_SS;
      mrd_req  <= 1'b0;
      mrd_addr <= '0;
      mwr_req  <= 1'b0;
      mwr_addr <= '0;
      mwr_data <= '0;
      mwr_size <= 1'b0;
      done     <= 1'b0;
      fault    <= 1'b0;
      new_cs   <= '0;
      new_eip  <= '0;
      new_cpl  <= '0;
      new_if   <= 1'b0;
      new_ss   <= '0;
      new_sp   <= '0;
    end else begin
      done  <= 1'b0;
      fault <= 1'b0;
      case (state)
        S_IDLE: begin
          if (irq_valid) begin
            cpl_q   <= cur_cpl;
            flags_q <= cur_flags;
            ip_q    <= cur_ip;
            sp_q    <= cur_sp;
            cs_q    <= cur_cs;
            ss_q    <= cur_ss;
            r0sp_q  <= ring0_sp;
            r0ss_q  <= ring0_ss;
            if (out_of_range) begin
              fault <= 1'b1;
            end else begin
              mrd_req  <= 1'b1;
              mrd_addr <= tbl_base + ADDR_W'({irq_vector, {SHIFT{1'b0}}});
              state    <= S_FETCH;
            end
          end
        end
        S_FETCH: begin
          if (mrd_rdy) begin
            mrd_req <= 1'b0;
            gate_q  <= mrd_data;
            state   <= S_CHECK;
          end
        end
        S_CHECK: begin
          if (!dec_ok) begin
            fault <= 1'b1;
            state <= S_IDLE;
          end else begin
            wide_q   <= dec_wide;
            trap_q   <= dec_trap;
            idx_q    <= first_idx;
            mwr_req  <= 1'b1;
            mwr_addr <= start_sp - step;
            mwr_data <= frame_data;
            mwr_size <= dec_wide;
            new_ss   <= priv_chg ? r0ss_q : ss_q;
            state    <= S_PUSH;
          end
        end
        S_PUSH: begin
          if (mwr_rdy) begin
            if (idx_q == IT_IP) begin
              mwr_req <= 1'b0;
              done    <= 1'b1;
              new_cs  <= dec_sel;
              new_eip <= wide_q ? dec_off : {16'h0, dec_off[15:0]};
              new_cpl <= 2'd0;
              new_if  <= trap_q ? flags_q[IF_BIT] : 1'b0;
              new_sp  <= 32'(mwr_addr);
              state   <= S_IDLE;
            end else begin
              idx_q    <= nxt_idx;
              mwr_addr <= mwr_addr - step;
              mwr_data <= frame_data;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/igs_checker.sv
module igs_checker #(
  parameter int ADDR_W = 32,
  parameter int DTR_W  = 48
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        cur_cpl,
  input logic              tbl_wr_en,
  input logic [DTR_W-1:0]  tbl_rd_data,
  input logic              busy,
  input logic              mrd_req,
  input logic              mrd_rdy,
  input logic [ADDR_W-1:0] mrd_addr,
  input logic              mwr_req,
  input logic              mwr_rdy,
  input logic [ADDR_W-1:0] mwr_addr,
  input logic [31:0]       mwr_data,
  input logic              mwr_size,
  input logic              done,
  input logic              fault,
  input logic [1:0]        new_cpl
);
  p_priv_write_r2: assert property (@(posedge clk) disable iff (rst)
    !(tbl_wr_en && cur_cpl == 2'd0) |=> $stable(tbl_rd_data));

  p_rd_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (mrd_req && !mrd_rdy) |=> (mrd_req && $stable(mrd_addr)));

  p_wr_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (mwr_req && !mwr_rdy) |=> (mwr_req && $stable(mwr_addr) && $stable(mwr_data)));

  p_sp_step_r8: assert property (@(posedge clk) disable iff (rst)
    (mwr_req && mwr_rdy) |=>
      (!mwr_req || (mwr_addr == $past(mwr_addr) - (mwr_size ? ADDR_W'(4) : ADDR_W'(2)))));

  p_excl_r10: assert property (@(posedge clk) disable iff (rst)
    !(done && fault));

  p_ring0_r10: assert property (@(posedge clk) disable iff (rst)
    done |-> (new_cpl == 2'd0));

  p_idle_end_r12: assert property (@(posedge clk) disable iff (rst)
    (done || fault) |-> !busy);

  p_quiet_idle_r12: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mrd_req && !mwr_req));
endmodule

bind intr_gate_seq igs_checker #(.ADDR_W(ADDR_W), .DTR_W(ADDR_W + LIM_W)) u_igs_chk (
  .clk(clk), .rst(rst), .cur_cpl(cur_cpl), .tbl_wr_en(tbl_wr_en),
  .tbl_rd_data(tbl_rd_data), .busy(busy), .mrd_req(mrd_req),
  .mrd_rdy(mrd_rdy), .mrd_addr(mrd_addr), .mwr_req(mwr_req),
  .mwr_rdy(mwr_rdy), .mwr_addr(mwr_addr), .mwr_data(mwr_data),
  .mwr_size(mwr_size), .done(done), .fault(fault), .new_cpl(new_cpl)
);

// File: tb/intr_gate_seq_bench.sv
`timescale 1ns/1ps
module intr_gate_seq_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  cur_cpl = '0;
  logic        tbl_wr_en = 1'b0;
  logic [47:0] tbl_wr_data = '0;
  logic [47:0] tbl_rd_data;
  logic        irq_valid = 1'b0;
  logic [7:0]  irq_vector = '0;
  logic        busy;
  logic [31:0] cur_flags = '0, cur_ip = '0, cur_sp = '0, ring0_sp = '0;
  logic [15:0] cur_cs = '0, cur_ss = '0, ring0_ss = '0;
  logic        mrd_req, mrd_rdy = 1'b0;
  logic [31:0] mrd_addr;
  logic [63:0] mrd_data;
  logic        mwr_req, mwr_rdy = 1'b0, mwr_size;
  logic [31:0] mwr_addr, mwr_data;
  logic        done, fault, new_if;
  logic [15:0] new_cs, new_ss;
  logic [31:0] new_eip, new_sp;
  logic [1:0]  new_cpl;

  always #4 clk = ~clk;

  intr_gate_seq u_intr_gate_seq (.*);

  int n_chk = 0, n_fail = 0, n_rd = 0, n_wr = 0, cyc = 0;
  logic [31:0] last_rd = '0;
  logic [31:0] tb_base = '0;
  logic [15:0] tb_limit = '0;
  logic [63:0] gate_mem [256];

  typedef struct packed { logic [31:0] a; logic [31:0] d; logic s; } wr_t;
  wr_t exp_q [$];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  // Memory model: stalling ready patterns, gate read by address
  always @(posedge clk) begin
    cyc++;
    mwr_rdy <= (cyc % 3) != 1;
    mrd_rdy <= (cyc % 4) == 2;
  end
  assign mrd_data = gate_mem[8'((mrd_addr - tb_base) >> 3)];

  // Monitor: scoreboard for stack writes, tally of reads
  always @(negedge clk) begin
    if (!rst && mrd_req && mrd_rdy) begin n_rd++; last_rd = mrd_addr; end
    if (!rst && mwr_req && mwr_rdy) begin
      n_wr++;
      if (exp_q.size() == 0) chk(0, "R6 unexpected write", {mwr_addr, mwr_data}, 64'h0);
      else begin
        wr_t e;
        e = exp_q.pop_front();
        chk(mwr_addr == e.a, "R6/R7 write address", 64'(mwr_addr), 64'(e.a));
        chk(mwr_data == e.d, "R7/R8 write data", 64'(mwr_data), 64'(e.d));
        chk(mwr_size == e.s, "R8 write size", 64'(mwr_size), 64'(e.s));
      end
    end
  end

  function automatic logic [63:0] mkgate(input logic [31:0] off, input logic [15:0] sel, input logic [15:0] attr);
    return {off[31:16], attr, sel, off[15:0]};
  endfunction

  task automatic tbl_write(input logic [1:0] cpl, input logic [47:0] v);
    @(negedge clk);
    cur_cpl = cpl; tbl_wr_en = 1'b1; tbl_wr_data = v;
    @(negedge clk);
    tbl_wr_en = 1'b0;
    if (cpl == 2'd0) begin tb_base = v[47:16]; tb_limit = v[15:0]; end
  endtask

  task automatic run_irq(input logic [7:0] vec, input logic [1:0] cpl, input logic [63:0] g,
                         input logic [31:0] fl, input logic [15:0] cs, input logic [31:0] ip,
                         input logic [15:0] ss, input logic [31:0] sp, input string tag);
    bit ok, oob, w, trp;
    logic [3:0] ty;
    logic [31:0] a, sz, eoff;
    logic [15:0] ess;
    int rd0, wr0, t;
    ty  = g[43:40];
    ok  = g[47] && !g[44] && (ty == 4'h6 || ty == 4'h7 || ty == 4'hE || ty == 4'hF);
    oob = (32'(vec) * 8 + 7) > 32'(tb_limit);
    w   = ty[3]; trp = ty[0];
    sz  = w ? 4 : 2;
    gate_mem[vec] = g;
    a   = (cpl != 0) ? ring0_sp : sp;
    ess = (cpl != 0) ? ring0_ss : ss;
    if (ok && !oob) begin
      if (cpl != 0) begin
        a -= sz; exp_q.push_back('{a, 32'(ss), w});
        a -= sz; exp_q.push_back('{a, w ? sp : {16'h0, sp[15:0]}, w});
      end
      a -= sz; exp_q.push_back('{a, w ? fl : {16'h0, fl[15:0]}, w});
      a -= sz; exp_q.push_back('{a, 32'(cs), w});
      a -= sz; exp_q.push_back('{a, w ? ip : {16'h0, ip[15:0]}, w});
    end
    rd0 = n_rd; wr0 = n_wr;
    @(negedge clk);
    cur_cpl = cpl; cur_flags = fl; cur_cs = cs; cur_ip = ip; cur_ss = ss; cur_sp = sp;
    irq_valid = 1'b1; irq_vector = vec;
    @(negedge clk);
    irq_valid = 1'b0;
    if (!oob) chk(busy == 1'b1, {tag, " R12 busy after accept"}, 64'(busy), 64'd1);
    t = 0;
    while (!(done || fault) && t < 300) begin @(negedge clk); t++; end
    chk(t < 300, {tag, " R10 completion"}, 64'(t), 64'd0);
    if (oob) begin
      chk(fault && !done, {tag, " R3 fault on limit"}, {done, fault}, 64'd1);
      chk(n_rd == rd0 && n_wr == wr0, {tag, " R3 no memory access"}, 64'(n_rd - rd0 + n_wr - wr0), 64'd0);
    end else begin
      chk(n_rd == rd0 + 1 && last_rd == tb_base + 32'(vec) * 8, {tag, " R4 gate read address"},
          64'(last_rd), 64'(tb_base + 32'(vec) * 8));
      if (!ok) begin
        chk(fault && !done, {tag, " R5 fault on bad gate"}, {done, fault}, 64'd1);
        chk(n_wr == wr0, {tag, " R5 no writes"}, 64'(n_wr - wr0), 64'd0);
      end else begin
        eoff = w ? {g[63:48], g[15:0]} : {16'h0, g[15:0]};
        chk(done && !fault, {tag, " R10 done pulse"}, {done, fault}, 64'd2);
        chk(exp_q.size() == 0, {tag, " R6 all items written"}, 64'(exp_q.size()), 64'd0);
        chk(new_cs == g[31:16], {tag, " R10 selector"}, 64'(new_cs), 64'(g[31:16]));
        chk(new_eip == eoff, {tag, " R10 offset"}, 64'(new_eip), 64'(eoff));
        chk(new_cpl == 2'd0 && new_ss == ess && new_sp == a, {tag, " R10 stack/cpl"},
            {new_cpl, new_ss, new_sp}, {2'd0, ess, a});
        chk(new_if == (trp ? fl[9] : 1'b0), {tag, " R9 new_if"}, 64'(new_if), 64'(trp ? fl[9] : 1'b0));
        @(negedge clk);
        chk(!done, {tag, " R10 single pulse"}, 64'(done), 64'd0);
      end
    end
    exp_q.delete();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    summary();
  end

  initial begin
    foreach (gate_mem[i]) gate_mem[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(tbl_rd_data == 48'h0, "R1 reset table", tbl_rd_data, 64'h0);
    chk(!busy && !done && !fault && !mwr_req && !mrd_req, "R12 reset idle",
        {busy, done, fault, mwr_req, mrd_req}, 64'h0);

    tbl_write(2'd0, {32'h0001_0000, 16'h07FF});
    chk(tbl_rd_data == {32'h0001_0000, 16'h07FF}, "R1 privileged load", tbl_rd_data, {32'h0001_0000, 16'h07FF});
    tbl_write(2'd3, {32'hDEAD_0000, 16'h0001});
    chk(tbl_rd_data == {32'h0001_0000, 16'h07FF}, "R2 unprivileged load ignored", tbl_rd_data, {32'h0001_0000, 16'h07FF});

    ring0_ss = 16'h0010; ring0_sp = 32'h0000_9000;
    // R6 R9: 32-bit interrupt gate (attr 0x8E00), same privilege
    run_irq(8'd8, 2'd0, mkgate(32'h0012_3456, 16'h0008, 16'h8E00),
            32'h0000_0202, 16'h0008, 32'h0000_1111, 16'h0018, 32'h0000_7000, "i32");
    // R7 R9: 32-bit trap gate from ring 3, IF set
    run_irq(8'd33, 2'd3, mkgate(32'hABCD_0100, 16'h0020, 16'h8F00),
            32'h0000_0246, 16'h001B, 32'h0040_2000, 16'h0023, 32'h00BF_FFF0, "t32");
    // R8: 16-bit interrupt gate, same privilege
    run_irq(8'd9, 2'd0, mkgate(32'h5555_0300, 16'h0030, 16'h8600),
            32'h0001_0202, 16'h0008, 32'h1234_5678, 16'h0018, 32'h0000_6000, "i16");
    // R7 R8 R9: 16-bit trap gate from ring 2, IF clear
    run_irq(8'd10, 2'd2, mkgate(32'h0000_0400, 16'h0038, 16'hC700),
            32'h0000_0046, 16'h002A, 32'h0000_0BEE, 16'h0032, 32'h0000_5000, "t16");
    // R5: not present, bad type, nonzero bit 44
    run_irq(8'd11, 2'd0, mkgate(32'h0000_0500, 16'h0008, 16'h0E00),
            32'h0, 16'h8, 32'h0, 16'h18, 32'h7000, "np");
    run_irq(8'd12, 2'd0, mkgate(32'h0000_0500, 16'h0008, 16'h8500),
            32'h0, 16'h8, 32'h0, 16'h18, 32'h7000, "ty5");
    run_irq(8'd13, 2'd0, mkgate(32'h0000_0500, 16'h0008, 16'h9E00),
            32'h0, 16'h8, 32'h0, 16'h18, 32'h7000, "sbit");
    // R3: limit of 8 entries, last inside and first beyond
    tbl_write(2'd0, {32'h0002_0000, 16'h003F});
    run_irq(8'd7, 2'd1, mkgate(32'h0000_0700, 16'h0008, 16'h8E00),
            32'h200, 16'h19, 32'h77, 16'h21, 32'h3000, "edge");
    run_irq(8'd8, 2'd0, mkgate(32'h0000_0800, 16'h0008, 16'h8E00),
            32'h200, 16'h8, 32'h88, 16'h18, 32'h3000, "oob");
    run_irq(8'd255, 2'd0, mkgate(32'h0000_0900, 16'h0008, 16'h8E00),
            32'h200, 16'h8, 32'h99, 16'h18, 32'h3000, "oob255");
    repeat (4) @(negedge clk);
    summary();
  end
endmodule